// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This block takes two 128-bit packed operands, A and B. Inside each operand it combines neighbouring elements two at a time: it adds them, or it subtracts the odd element from the even one. Results from A fill the low half of the output word and results from B fill the high half, each in lane order. The elements are either 16-bit (eight lanes per operand) or 32-bit (four lanes per operand). In 16-bit mode the unit can wrap on overflow or clamp to the signed range. In 32-bit mode it always wraps.

One request is accepted per clock while `in_valid` is high. The packed result is registered and appears one cycle later, together with `out_valid`. In cycles with no request the output register keeps its last value, so a downstream consumer can read it at any time.

Top module: `hpair_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` and `result` to zero. After reset, `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result` holds the answer to that request.
- R2: With `wide_sel`=0 (16-bit elements), lane i of any vector occupies bits [16i+15:16i]. Result lane k (k=0..3) combines A lanes 2k and 2k+1, and result lane 4+k combines B lanes 2k and 2k+1.
- R3: With `sub_sel`=1 each result is the even lane minus the odd lane (lane 2k minus lane 2k+1). With `sub_sel`=0 it is their sum.
- R4: With `sat_en`=0, 16-bit results wrap modulo 2^16; for example, 0x7FFF plus 0x0001 gives 0x8000.
- R5: With `sat_en`=1 and `wide_sel`=0, a true result above 0x7FFF becomes 0x7FFF and a true result below -0x8000 becomes 0x8000. Results in range are exact.
- R6: With `wide_sel`=1 (32-bit elements, lane i at bits [32i+31:32i]), result lanes 0 and 1 come from A lane pairs (0,1) and (2,3), and result lanes 2 and 3 come from the same pairs of B.
- R7: In 32-bit mode results always wrap modulo 2^32, and `sat_en` has no effect on the result.
- R8: In a cycle with `in_valid` low, `result` keeps its previous value and `out_valid` is low, whatever is on the operand and control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_a | input | 128 | Packed operand A |
| op_b | input | 128 | Packed operand B |
| wide_sel | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| sub_sel | input | 1 | 0: add pairs, 1: even minus odd |
| sat_en | input | 1 | 1: saturate (16-bit mode only) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Packed pair results |

## Verification
The assertions assume that `rst` is held for at least one clock before the first request. They also assume that the control inputs are known (not X) whenever `in_valid` is high, since their conclusions are drawn from the values sampled in that request cycle. The scoreboard driver changes inputs only on the falling clock edge and keeps every control bit at a defined 0 or 1, including in idle cycles. In idle cycles it drives random operand values with `in_valid` low, so the hold property and the hold checks see real activity on the inputs that must be ignored.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
   typedef enum logic {ELEM_NARROW = 1'b0, ELEM_WIDE = 1'b1} elem_e;
   typedef enum logic {PAIR_ADD = 1'b0, PAIR_SUB = 1'b1} pair_op_e;
endpackage

// File: rtl/hpair_op.sv
module hpair_op #(
   parameter int W       = 16,
   parameter bit SAT_CAP = 1'b1
) (
   input  logic [W-1:0] even_i,
   input  logic [W-1:0] odd_i,
   input  logic         sub_i,
   input  logic         sat_i,
   output logic [W-1:0] res_o
);
   logic [W:0] ev_x, od_x, ext;

   assign ev_x = {even_i[W-1], even_i};
   assign od_x = {odd_i[W-1], odd_i};
   assign ext  = sub_i ? (ev_x - od_x) : (ev_x + od_x);

   generate
      if (SAT_CAP) begin : g_sat
         localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
         localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};
         always_comb begin
            if (sat_i && (ext[W] != ext[W-1]))
               res_o = ext[W] ? NEG_MIN : POS_MAX;
            else
               res_o = ext[W-1:0];
         end
      end else begin : g_wrap
         logic unused_sat;
         assign unused_sat = sat_i;
         assign res_o      = ext[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/hpair_stage.sv
module hpair_stage #(
   parameter int W = 128
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic         vld_o,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         q_o   <= '0;
      end else begin
         vld_o <= load_i;
         if (load_i) q_o <= d_i;
      end
   end
endmodule

// File: rtl/hpair_unit.sv
module hpair_unit #(
   parameter int DATA_W   = 128,
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              wide_sel,
   input  logic              sub_sel,
   input  logic              sat_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import hpair_pkg::*;

   localparam int NARROW_N    = DATA_W / NARROW_W;
   localparam int WIDE_N      = DATA_W / WIDE_W;
   localparam int NARROW_HALF = NARROW_N / 2;
   localparam int WIDE_HALF   = WIDE_N / 2;

   generate
      if (DATA_W % (2 * NARROW_W) != 0) begin : g_bad_narrow
         $error("DATA_W must hold an even number of narrow elements");
      end
      if (DATA_W % (2 * WIDE_W) != 0) begin : g_bad_wide
         $error("DATA_W must hold an even number of wide elements");
      end
   endgenerate

   elem_e    elem_mode;
   pair_op_e pair_op;
   assign elem_mode = elem_e'(wide_sel);
   assign pair_op   = pair_op_e'(sub_sel);

   logic [DATA_W-1:0] narrow_res, wide_res, next_res;

   // 16-bit lanes: low half from A pairs, high half from B pairs
   for (genvar j = 0; j < NARROW_N; j++) begin : g_nl
      localparam int K = j % NARROW_HALF;
      logic [NARROW_W-1:0] ev, od;
      if (j < NARROW_HALF) begin : g_a
         assign ev = op_a[(2*K)*NARROW_W +: NARROW_W];
         assign od = op_a[(2*K+1)*NARROW_W +: NARROW_W];
      end else begin : g_b
         assign ev = op_b[(2*K)*NARROW_W +: NARROW_W];
         assign od = op_b[(2*K+1)*NARROW_W +: NARROW_W];
      end
      hpair_op #(.W(NARROW_W), .SAT_CAP(1'b1)) u_op (
         .even_i (ev),
         .odd_i  (od),
         .sub_i  (pair_op == PAIR_SUB),
         .sat_i  (sat_en),
         .res_o  (narrow_res[j*NARROW_W +: NARROW_W])
      );
   end

   // 32-bit lanes: always wrapping
   for (genvar j = 0; j < WIDE_N; j++) begin : g_wl
      localparam int K = j % WIDE_HALF;
      logic [WIDE_W-1:0] ev, od;
      if (j < WIDE_HALF) begin : g_a
         assign ev = op_a[(2*K)*WIDE_W +: WIDE_W];
         assign od = op_a[(2*K+1)*WIDE_W +: WIDE_W];
      end else begin : g_b
         assign ev = op_b[(2*K)*WIDE_W +: WIDE_W];
         assign od = op_b[(2*K+1)*WIDE_W +: WIDE_W];
      end
      hpair_op #(.W(WIDE_W), .SAT_CAP(1'b0)) u_op (
         .even_i (ev),
         .odd_i  (od),
         .sub_i  (pair_op == PAIR_SUB),
         .sat_i  (1'b0),
         .res_o  (wide_res[j*WIDE_W +: WIDE_W])
      );
   end

   assign next_res = (elem_mode == ELEM_WIDE) ? wide_res : narrow_res;

   hpair_stage #(.W(DATA_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .load_i (in_valid),
      .d_i    (next_res),
      .vld_o  (out_valid),
      .q_o    (result)
   );
endmodule

// File: rtl/hpair_unit_chk.sv
module hpair_unit_chk #(
   parameter int DATA_W = 128
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic              wide_sel,
   input logic              sub_sel,
   input logic              sat_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0)); // R1

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result))); // R8

   AST_SAT_POS_PAIR: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wide_sel && sat_en && !sub_sel && !op_a[15] && !op_a[31])
      |=> !result[15]); // R5

   AST_B_EQUAL_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wide_sel && sub_sel && op_b[15:0] == op_b[31:16])
      |=> result[79:64] == 16'h0000); // R2

   AST_WIDE_WRAP_ADD: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wide_sel && !sub_sel)
      |=> result[31:0] == $past(op_a[31:0] + op_a[63:32])); // R7
endmodule

bind hpair_unit hpair_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .wide_sel  (wide_sel),
   .sub_sel   (sub_sel),
   .sat_en    (sat_en),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/tb_hpair_unit.sv
module tb_hpair_unit;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [127:0] op_a, op_b;
   logic         wide_sel, sub_sel, sat_en;
   logic         out_valid;
   logic [127:0] result;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [127:0] val;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   hpair_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .wide_sel(wide_sel), .sub_sel(sub_sel), .sat_en(sat_en),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input logic wide, input logic sub, input logic sat);
      logic [127:0] r;
      r = '0;
      if (!wide) begin
         for (int j = 0; j < 8; j++) begin
            logic [127:0] s;
            int e, o, v;
            s = (j < 4) ? a : b;
            e = int'($signed(s[32*(j%4) +: 16]));
            o = int'($signed(s[32*(j%4)+16 +: 16]));
            v = sub ? e - o : e + o;
            if (sat) begin
               if (v > 32767)  v = 32767;
               if (v < -32768) v = -32768;
            end
            r[16*j +: 16] = v[15:0];
         end
      end else begin
         for (int j = 0; j < 4; j++) begin
            logic [127:0] s;
            longint e, o, v;
            s = (j < 2) ? a : b;
            e = longint'($signed(s[64*(j%2) +: 32]));
            o = longint'($signed(s[64*(j%2)+32 +: 32]));
            v = sub ? e - o : e + o;
            r[32*j +: 32] = v[31:0];
         end
      end
      return r;
   endfunction

   function automatic logic [127:0] pk16(input logic [15:0] l0, l1, l2, l3, l4, l5, l6, l7);
      return {l7, l6, l5, l4, l3, l2, l1, l0};
   endfunction

   function automatic logic [127:0] pk32(input logic [31:0] l0, l1, l2, l3);
      return {l3, l2, l1, l0};
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [127:0] a, input logic [127:0] b, input logic wide,
                       input logic sub, input logic sat, input string tag);
      exp_t item;
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b;
      wide_sel = wide; sub_sel = sub; sat_en = sat;
      item.val = model(a, b, wide, sub, sat);
      item.tag = tag;
      sb.push_back(item);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      op_a = {4{$urandom()}}; op_b = {4{$urandom()}};
      wide_sel = 1'($urandom()); sub_sel = 1'($urandom()); sat_en = 1'($urandom());
   endtask

   // monitor: compares each result against the scoreboard
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R1 unexpected out_valid", result, '0);
         end else begin
            exp_t item;
            item = sb.pop_front();
            check(result == item.val, item.tag, result, item.val);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 128'h0, 128'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [127:0] snap;
      rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
      wide_sel = 1'b0; sub_sel = 1'b0; sat_en = 1'b0;
      repeat (3) @(negedge clk);
      check(!out_valid && result == '0, "R1 reset state", result, '0);
      rst = 1'b0;

      // R2 lane placement, add
      send(pk16(1, 2, 3, 4, 5, 6, 7, 8), pk16(4, 128, 4, 3, 24, 12, 6, 19), 0, 0, 0, "R2 add placement");
      // R3 subtraction even minus odd
      send(pk16(1, 2, 3, 4, 5, 6, 7, 8), pk16(4, 128, 4, 3, 24, 12, 6, 19), 0, 1, 0, "R3 sub even-odd");
      // R4 wrap 0x7FFF+1 = 0x8000
      send(pk16(16'h7FFF, 1, 16'h7FFF, 2, 16'h8000, 16'hFFFF, 16'h8000, 5),
           pk16(16'h8000, 1, 16'h7FFF, 16'hFFFF, 0, 0, 1, 1), 0, 0, 0, "R4 wrap add");
      send(pk16(16'h7FFF, 16'hFFFF, 16'h8000, 1, 0, 0, 0, 0),
           pk16(0, 16'h8000, 5, 5, 0, 0, 0, 0), 0, 1, 0, "R4 wrap sub");
      // R5 saturation both directions
      send(pk16(16'h7FFF, 1, 16'h7FFF, 16'h7FFF, 16'h8000, 16'hFFFF, 100, 200),
           pk16(16'h8000, 16'h8000, 16'h8000, 1, 32767, 1, 16'h8000, 16'hFFFF), 0, 0, 1, "R5 sat add");
      send(pk16(16'h7FFF, 16'hFFFF, 16'h8000, 1, 16'h8000, 16'h8000, 7, 9),
           pk16(0, 16'h8000, 16'h7FFF, 16'h8000, 16'hFFFF, 1, 3, 3), 0, 1, 1, "R5 sat sub");
      // R6 wide placement, R7 wrap and sat_en ignored
      send(pk32(1, 2, 3, 4), pk32(4, 128, 4, 3), 1, 0, 0, "R6 wide add placement");
      send(pk32(1, 2, 3, 4), pk32(4, 128, 4, 3), 1, 1, 0, "R6 wide sub");
      send(pk32(32'h7FFFFFFF, 1, 32'h7FFFFFFF, 2), pk32(32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFE),
           1, 0, 1, "R7 wide wrap with sat_en");
      send(pk32(32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1), pk32(0, 32'h80000000, 5, 6),
           1, 1, 1, "R7 wide sub wrap with sat_en");
      idle();
      snap = result;
      // R8 hold while idle with changing inputs
      repeat (3) idle();
      check(!out_valid && result == snap, "R8 hold while idle", result, snap);

      // random back-to-back with occasional gaps
      for (int i = 0; i < 300; i++) begin
         logic w, s, t;
         w = 1'($urandom()); s = 1'($urandom()); t = 1'($urandom());
         send({$urandom(), $urandom(), $urandom(), $urandom()},
              {$urandom(), $urandom(), $urandom(), $urandom()}, w, s, t,
              w ? "R6 R7 random wide" : (t ? "R5 random sat" : "R2 R3 R4 random wrap"));
         if (($urandom() % 5) == 0) begin
            idle();
            snap = result;
            idle();
            check(!out_valid && result == snap, "R8 hold random gap", result, snap);
         end
      end
      idle();
      idle();
      check(sb.size() == 0, "R1 all results delivered", 128'(sb.size()), '0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule